// File: doc/BRIEF.md
# Serially Controlled Clock Fanout Enable Block

This block sits beside a clock fanout and decides which of its copies of a single reference clock actually toggle. A two-wire serial slave, oversampled by a fast system clock, holds one enable bit per output. After reset every output runs. A bus master can stop or restart single outputs by writing one register at a time. It can read a register back through a repeated START. It can also load several registers at once with a counted block write. A separate active-low pin puts every output driver into high impedance for board test, whatever the enable bits hold.

Each enable bit reaches its output through a flop clocked on the falling edge of the reference clock. A switched output therefore starts or stops only on a whole high phase. The serial side never stretches SCL, and the block has no valid/ready stream port. The bus sets the pace: every byte addressed to this slave is acknowledged within the low phase of SCL that follows it. This leaves no back-pressure path.

Top module: `clk_fanout_ctl`

## Requirements
- R1: After reset every enable bit is 1, so all outputs run. Registers 0 and 1 read 0xFF and register 2 reads 0x03.
- R2: Bit b of register r controls output 8*r+b. A 1 lets the reference clock through to that output. A 0 holds the output low.
- R3: While `oe_n_i` is low, every bit of `clk_drv_o` is 0 (high impedance) whatever the register contents. While it is high, every bit is 1.
- R4: A random write is START, address byte with bit 0 = 0, register byte with bit 7 = 0 (bits 6:0 = register), data byte, STOP. Each byte is acknowledged. Any further data byte before STOP is acknowledged and discarded.
- R5: A random read sets the register with a write of the register byte. It then sends a repeated START and the address byte with bit 0 = 1. The slave returns the register MSB first. After the master's NACK it releases SDA.
- R6: Register 2 bits 7:2 read as 0. Registers 3 and above read 0x00, and writes to them change no output.
- R7: Address bits 7:1 of the address byte are compared with `DEV_ADDR`, and bit 2 of the 7-bit address is ignored. With the default 0x69, exactly the addresses 0x69 and 0x6D are acknowledged.
- R8: An address byte that does not match gets no acknowledge. The rest of that transfer changes no register.
- R9: In a block write, the register byte has bit 7 = 1. It is followed by a count byte and then data bytes. Those bytes go to registers 0, 1, 2 in turn. Bytes beyond the count or beyond register 2 are acknowledged and discarded.
- R10: An output's enable changes only while the reference clock is low. No output high pulse is shorter than the reference high phase.
- R11: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| oe_n_i | input | 1 | Active-low global output-driver enable |
| clk_out_o | output | NUM_OUT | Gated copies of the reference clock |
| clk_drv_o | output | NUM_OUT | Per-output driver enable, 0 = high impedance |

## Verification
The reference clock is free-running and unrelated to the system clock. A register write finishing and an output's high phase can therefore fall in the same instant. The bench issues many writes that flip individual enables, and their completion times drift across the reference period. An event monitor measures the width of every high pulse on every output and counts any pulse shorter than the high phase as a failure. A second overlap is a bus write arriving while `oe_n_i` is low. This case is judged at the ports: the driver enables stay 0, and the gated outputs still follow the newly written bits.

// File: rtl/clkfo_pkg.sv
package clkfo_pkg;
  // serial slave protocol phases
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WDATA,
    S_DISCARD,
    S_COUNT,
    S_BLOCK,
    S_READ
  } twi_state_e;

  localparam int BYTE_W   = 8;
  localparam int REGPTR_W = 7;
endpackage

// File: rtl/clkfo_line_sync.sv
module clkfo_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
      sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_q     = scl_ff[STAGES-1];
  assign sda_q     = sda_ff[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/clkfo_twi_slave.sv
module clkfo_twi_slave
  import clkfo_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [6:0] ADDR_MASK = 7'h7B,
  parameter int         NREG      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                sda_q,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                sda_oe,
  output logic                wr_en,
  output logic [REGPTR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0]   wr_data,
  output logic [REGPTR_W-1:0] rd_addr
);
  localparam logic [REGPTR_W-1:0] LAST = REGPTR_W'(NREG);

  twi_state_e          st;
  logic [3:0]          cnt;
  logic [BYTE_W-1:0]   shreg, tx, remain;
  logic [REGPTR_W-1:0] ptr, idx;
  logic                mnack;
  logic                addr_hit;
  logic [2:0]          bsel;

  assign addr_hit = ((shreg[7:1] ^ DEV_ADDR) & ADDR_MASK) == '0;
  assign bsel     = 3'(4'd7 - cnt);
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      remain  <= '0;
      ptr     <= '0;
      idx     <= '0;
      mnack   <= 1'b1;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            shreg <= {shreg[6:0], sda_q};
            cnt   <= cnt + 4'd1;
          end else begin
            mnack <= sda_q;          // acknowledge clock
            cnt   <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            // a full byte has been shifted: decide the acknowledge
            case (st)
              S_ADDR: begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  st     <= shreg[0] ? S_READ : S_CMD;
                end else begin
                  sda_oe <= 1'b0;
                  st     <= S_IDLE;
                end
              end
              S_CMD: begin
                sda_oe <= 1'b1;
                if (shreg[7]) begin
                  st  <= S_COUNT;
                  idx <= '0;
                end else begin
                  ptr <= shreg[6:0];
                  st  <= S_WDATA;
                end
              end
              S_WDATA: begin
                sda_oe <= 1'b1;
                st     <= S_DISCARD;
                if (ptr < LAST) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                end
              end
              S_DISCARD: sda_oe <= 1'b1;
              S_COUNT: begin
                sda_oe <= 1'b1;
                remain <= shreg;
                st     <= S_BLOCK;
              end
              S_BLOCK: begin
                sda_oe <= 1'b1;
                if (remain != '0) begin
                  remain <= remain - 8'd1;
                  if (idx < LAST) begin
                    wr_en   <= 1'b1;
                    wr_addr <= idx;
                    wr_data <= shreg;
                  end
                  if (idx != '1) idx <= idx + 7'd1;
                end
              end
              S_READ: begin
                sda_oe <= 1'b0;      // master drives the acknowledge
                ptr    <= ptr + 7'd1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (st == S_READ) begin
              if (mnack) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
              end else begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
              end
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (st == S_READ && cnt != '0) begin
            sda_oe <= ~tx[bsel];
          end
        end
      end
    end
  end
endmodule

// File: rtl/clkfo_enable_regs.sv
module clkfo_enable_regs
  import clkfo_pkg::*;
#(
  parameter int NUM_OUT = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REGPTR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [REGPTR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [NUM_OUT-1:0]  en
);
  localparam int NREG = (NUM_OUT + 7) / 8;
  localparam int PADW = NREG * 8;

  logic [PADW-1:0] padded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (int'(wr_addr) == i / 8) en[i] <= wr_data[i % 8];
      end
    end
  end

  assign padded  = PADW'(en);
  assign rd_data = (int'(rd_addr) < NREG) ? padded[8*int'(rd_addr) +: 8] : 8'h00;
endmodule

// File: rtl/clkfo_out_gate.sv
module clkfo_out_gate #(
  parameter int NUM_OUT = 18
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] en_held,
  output logic [NUM_OUT-1:0] clk_out
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic held;
    // captured while the reference is low, stable through its high phase
    always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) held <= 1'b1;
      else        held <= en[g];
    end
    assign en_held[g] = held;
    assign clk_out[g] = ref_clk & held;
  end
endmodule

// File: rtl/clk_fanout_ctl.sv
module clk_fanout_ctl
  import clkfo_pkg::*;
#(
  parameter int         NUM_OUT      = 18,
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         DONTCARE_BIT = 2
) (
  input  logic               sys_clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               ref_clk_i,
  input  logic               oe_n_i,
  output logic [NUM_OUT-1:0] clk_out_o,
  output logic [NUM_OUT-1:0] clk_drv_o
);
  localparam int         NREG      = (NUM_OUT + 7) / 8;
  localparam logic [6:0] ADDR_MASK = ~(7'd1 << DONTCARE_BIT);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                wr_en;
  logic [REGPTR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0]   wr_data, rd_data;
  logic [NUM_OUT-1:0]  en_vec, en_held;

  clkfo_line_sync #(.STAGES(2)) u_sync (
    .clk(sys_clk), .rst_n(rst_n), .scl_pin(scl_i), .sda_pin(sda_i),
    .scl_q(scl_s), .sda_q(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkfo_twi_slave #(.DEV_ADDR(DEV_ADDR), .ADDR_MASK(ADDR_MASK), .NREG(NREG)) u_slave (
    .clk(sys_clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_q(sda_s), .rd_data(rd_data),
    .sda_oe(sda_pull_o), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr)
  );

  clkfo_enable_regs #(.NUM_OUT(NUM_OUT)) u_regs (
    .clk(sys_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .en(en_vec)
  );

  clkfo_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .ref_clk(ref_clk_i), .rst_n(rst_n), .en(en_vec), .en_held(en_held),
    .clk_out(clk_out_o)
  );

  assign clk_drv_o = {NUM_OUT{oe_n_i}};
endmodule

// File: rtl/clkfo_checker.sv
module clkfo_checker #(
  parameter int N = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_q,
  input logic         sda_oe,
  input logic         wr_en,
  input logic [N-1:0] en,
  input logic [N-1:0] en_held,
  input logic         ref_clk,
  input logic         oe_n,
  input logic [N-1:0] drv
);
  a_r1_reset_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == '1));

  a_r3_oe_forces_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (drv == '0));

  a_r3_oe_drives: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (drv == '1));

  a_r4_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en));

  a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clk && $past(ref_clk)) |-> $stable(en_held));

  a_r11_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> !$rose(sda_oe));
endmodule

bind clk_fanout_ctl clkfo_checker #(.N(NUM_OUT)) u_chk (
  .clk(sys_clk), .rst_n(rst_n), .scl_q(scl_s), .sda_oe(sda_pull_o),
  .wr_en(wr_en), .en(en_vec), .en_held(en_held), .ref_clk(ref_clk_i),
  .oe_n(oe_n_i), .drv(clk_drv_o)
);

// File: tb/clk_fanout_ctl_bench.sv
`timescale 1ns/100ps
module clk_fanout_ctl_bench;
  localparam int         N   = 18;
  localparam logic [6:0] DEV = 7'h69;
  localparam int         Q   = 5;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, oe_n = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, sda_line;
  logic [N-1:0] clk_out, clk_drv;
  logic [N-1:0] exp_en = '1;
  int vectors = 0, errors = 0, runts = 0, early_pull = 0;
  real t_rise [N];
  logic [N-1:0] prev_out = '0;

  assign sda_line = m_sda & ~sda_pull;

  always #5 clk = ~clk;
  initial begin #3; forever #35 ref_clk = ~ref_clk; end

  clk_fanout_ctl u_clk_fanout_ctl (
    .sys_clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .ref_clk_i(ref_clk), .oe_n_i(oe_n),
    .clk_out_o(clk_out), .clk_drv_o(clk_drv)
  );

  // R10 pulse-width monitor, R11 pull monitor
  always @(clk_out) begin
    for (int i = 0; i < N; i++) begin
      if (prev_out[i] !== 1'b1 && clk_out[i] === 1'b1) t_rise[i] = $realtime;
      if (prev_out[i] === 1'b1 && clk_out[i] === 1'b0 && rst_n &&
          ($realtime - t_rise[i]) < 30.0) runts++;
    end
    prev_out = clk_out;
  end
  always @(posedge sda_pull) if (m_scl) early_pull++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; tq(Q); m_scl = 1'b1; tq(Q); m_sda = 1'b0; tq(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    tq(Q); m_sda = 1'b0; tq(Q); m_scl = 1'b1; tq(Q); m_sda = 1'b1; tq(2*Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    tq(Q); m_sda = b; tq(Q); m_scl = 1'b1; tq(Q); r = sda_line; tq(Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(nack, r);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                        output logic ack);
    logic k;
    bus_start;
    send_byte({a, 1'b0}, ack);
    if (ack) begin send_byte(r, k); send_byte(d, k); end
    bus_stop;
  endtask

  task automatic rd_reg(input logic [7:0] r, output logic [7:0] d);
    logic k;
    bus_start;
    send_byte({DEV, 1'b0}, k);
    send_byte(r, k);
    bus_start;
    send_byte({DEV, 1'b1}, k);
    recv_byte(1'b1, d);
    chk("R5 released after nack", {31'd0, sda_pull}, 32'd0);
    bus_stop;
  endtask

  function automatic void model_write(input int r, input logic [7:0] v);
    for (int k = 0; k < 8; k++) if (r * 8 + k < N) exp_en[r*8+k] = v[k];
  endfunction

  function automatic logic [7:0] model_read(input int r);
    logic [7:0] v = 8'h00;
    for (int k = 0; k < 8; k++) if (r < 3 && r * 8 + k < N) v[k] = exp_en[r*8+k];
    return v;
  endfunction

  task automatic chk_out(input string req);
    repeat (3) @(posedge ref_clk);
    #10;
    chk({req, " high phase"}, 32'(clk_out), 32'(exp_en));
    chk({req, " drivers"}, 32'(clk_drv), oe_n ? 32'h3FFFF : 32'h0);
    @(negedge ref_clk);
    #10;
    chk({req, " low phase"}, 32'(clk_out), 32'd0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run;
  end

  initial begin
    logic ack, k;
    logic [7:0] d;
    tq(4); rst_n = 1'b1; tq(4);

    // R1 reset state
    chk_out("R1 reset");
    for (int r = 0; r < 3; r++) begin
      rd_reg(8'(r), d);
      chk("R1 reset readback", 32'(d), (r == 2) ? 32'h03 : 32'hFF);
    end

    // R2/R4/R5 walking zero over every output
    for (int b = 0; b < N; b++) begin
      logic [7:0] v;
      v = ~(8'd1 << (b % 8));
      wr_reg(DEV, 8'(b / 8), v, ack);
      chk("R4 address ack", {31'd0, ack}, 32'd1);
      model_write(b / 8, v);
      chk_out("R2 walking zero");
      rd_reg(8'(b / 8), d);
      chk("R5 readback", 32'(d), 32'(model_read(b / 8)));
      wr_reg(DEV, 8'(b / 8), 8'hFF, ack);
      model_write(b / 8, 8'hFF);
    end

    // R3 output enable low, with a write landing meanwhile
    oe_n = 1'b0;
    wr_reg(DEV, 8'd1, 8'h5A, ack);
    model_write(1, 8'h5A);
    chk_out("R3 oe low");
    chk("R3 all hiz", 32'(clk_drv), 32'd0);
    oe_n = 1'b1;
    chk_out("R3 oe high");

    // R4 extra data byte discarded
    bus_start;
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h00, k);
    send_byte(8'hC3, k);
    send_byte(8'h00, ack);
    chk("R4 extra byte acked", {31'd0, ack}, 32'd1);
    bus_stop;
    model_write(0, 8'hC3);
    chk_out("R4 extra byte discarded");

    // R6 unused bits and absent registers
    wr_reg(DEV, 8'd2, 8'hFF, ack);
    model_write(2, 8'hFF);
    rd_reg(8'd2, d);
    chk("R6 reg2 upper bits zero", 32'(d), 32'h03);
    wr_reg(DEV, 8'd5, 8'h00, ack);
    chk_out("R6 absent reg write ignored");
    rd_reg(8'd5, d);
    chk("R6 absent reg reads zero", 32'(d), 32'h00);

    // R7 address sweep
    for (int a = 0; a < 128; a++) begin
      bus_start;
      send_byte({7'(a), 1'b0}, ack);
      bus_stop;
      chk("R7 address match", {31'd0, ack},
          ((7'(a) & 7'h7B) == (DEV & 7'h7B)) ? 32'd1 : 32'd0);
    end
    wr_reg(DEV ^ 7'h04, 8'd0, 8'h3C, ack);
    chk("R7 alias ack", {31'd0, ack}, 32'd1);
    model_write(0, 8'h3C);
    chk_out("R7 alias write");

    // R8 mismatch ignored
    bus_start;
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    send_byte(8'h00, k);
    send_byte(8'h00, k);
    bus_stop;
    chk("R8 no ack", {31'd0, ack}, 32'd0);
    chk_out("R8 no change");

    // R9 block writes
    bus_start;
    send_byte({DEV, 1'b0}, k);
    send_byte(8'h80, k);
    send_byte(8'd2, k);
    send_byte(8'h11, k);
    send_byte(8'h22, k);
    send_byte(8'h33, ack);
    bus_stop;
    chk("R9 beyond count acked", {31'd0, ack}, 32'd1);
    model_write(0, 8'h11); model_write(1, 8'h22);
    chk_out("R9 count two");
    bus_start;
    send_byte({DEV, 1'b0}, k);
    send_byte(8'h80, k);
    send_byte(8'd5, k);
    send_byte(8'hF0, k);
    send_byte(8'h0F, k);
    send_byte(8'hFE, k);
    send_byte(8'hAA, k);
    send_byte(8'h55, ack);
    bus_stop;
    chk("R9 beyond last reg acked", {31'd0, ack}, 32'd1);
    model_write(0, 8'hF0); model_write(1, 8'h0F); model_write(2, 8'hFE);
    chk_out("R9 count five");
    rd_reg(8'd2, d);
    chk("R9 reg2 readback", 32'(d), 32'h02);
    bus_start;
    send_byte({DEV, 1'b0}, k);
    send_byte(8'h80, k);
    send_byte(8'd0, k);
    send_byte(8'h00, k);
    bus_stop;
    chk_out("R9 count zero");

    chk("R10 runt pulses", 32'(runts), 32'd0);
    chk("R11 pull while scl high", 32'(early_pull), 32'd0);
    finish_run;
  end
endmodule